// File: doc/BRIEF.md
# Streaming 2x2 Fixed-Point Convolution Engine

This block takes one image at a time as a raster-ordered stream of signed fixed-point samples, one sample per qualified beat, and produces the response of a single 2x2 kernel at every position where the kernel fits entirely inside the image. A single line of storage keeps the previous row. Two further registers keep the diagonal and left neighbours, so each incoming sample completes at most one window. The four taps are multiplied in parallel. Each product is rescaled and clipped, and a registered saturating adder tree reduces the four scaled products to one sum. A constant bias is then added.

The kernel coefficients and the bias are fixed when the block is elaborated. There is no path to change them at run time. The output carries its own valid flag and cannot stall the producer. Images may follow one another with no gap. Idle beats may appear anywhere in the stream.

Position tracking is a small state machine with three states:
- `ST_FIRST_ROW`: the top row of an image, where no window is ever complete.
- `ST_ROW_HEAD`: column 0 of any later row.
- `ST_BODY`: every other position, where each beat completes a window.

The transitions are:
- `T_ROW0_DONE`: the last sample of the top row moves the machine from `ST_FIRST_ROW` to `ST_ROW_HEAD`.
- `T_HEAD_TO_BODY`: any accepted beat moves it from `ST_ROW_HEAD` to `ST_BODY`.
- `T_NEXT_ROW`: the last sample of an inner row moves it from `ST_BODY` to `ST_ROW_HEAD`.
- `T_IMAGE_DONE`: the last sample of the image moves it from `ST_BODY` back to `ST_FIRST_ROW`.

Top module: `conv2x2_stream`

## Requirements
- R1: All samples, coefficients, bias and results are 32-bit two's-complement values with 30 fraction bits. The output for the window completed by the sample at (row r, column c) uses four taps:
  - TL is the sample at (r-1, c-1).
  - TR is the sample at (r-1, c).
  - BL is the sample at (r, c-1).
  - BR is the sample at (r, c).
  Each tap is multiplied by its own coefficient W_TL, W_TR, W_BL or W_BR.
- R2: Each full 64-bit product is shifted arithmetically right by 30 bits, which rounds toward minus infinity. The shifted value is then clipped to the range -2^31 to 2^31-1.
- R3: Let q_TL, q_TR, q_BL and q_BR be the clipped products. The result is computed as follows, where sat clips to the same 32-bit range:
  - a = sat(q_TL + q_TR)
  - b = sat(q_BL + q_BR)
  - t = sat(a + b)
  - y = sat(t + BIAS)
- R4: A window is produced only for row >= 1 and column >= 1. A 28x28 image therefore yields exactly 729 outputs, and none for the first row or the first column.
- R5: A sample is taken at the rising edge where valid_in is 1. Its output appears with valid_out = 1 exactly 6 clock edges later. valid_out is 0 in every other cycle.
- R6: A cycle with valid_in = 0 changes neither the position nor the stored neighbours. pixel_in is ignored in such a cycle.
- R7: Position wraps after the 784th accepted sample. The next sample is row 0, column 0 of a new image, and needs no idle cycle in between.
- R8: A synchronous reset clears the position, the line storage and every valid stage. After reset valid_out is 0, and the stream restarts at row 0, column 0 even if the reset came mid-image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies pixel_in on this edge |
| pixel_in | input | 32 | Input sample, signed, 30 fraction bits |
| valid_out | output | 1 | Qualifies pixel_out |
| pixel_out | output | 32 | Convolution result, signed, 30 fraction bits |

## Verification
The assertions take for granted that valid_in and pixel_in are never unknown once reset is released. They also assume that valid_in stays low while reset is held, so no beat is taken during reset. The latency assertion relies on that, because it looks back six cycles only once six clean cycles have passed since reset. The stimulus holds valid_in at 0 around each reset. Whenever valid_in is low it drives pixel_in with deliberately changing values, so any leak from an idle cycle shows up at the output. Full-scale extremes in alternating columns and rows drive the products and sums into both clipping limits within the legal input range.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int DATA_W = 32;
    localparam int FRAC_W = 30;
    localparam int PROD_W = 2 * DATA_W;
    localparam int TAPS   = 4;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic [1:0] {
        ST_FIRST_ROW = 2'd0,
        ST_ROW_HEAD  = 2'd1,
        ST_BODY      = 2'd2
    } pos_state_t;

    localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // rescale a full product to the word format, clipping at the limits
    function automatic word_t sat_prod(input prod_t p);
        prod_t s;
        s = p >>> FRAC_W;
        if (s > prod_t'(WORD_MAX)) return WORD_MAX;
        if (s < prod_t'(WORD_MIN)) return WORD_MIN;
        return word_t'(s[DATA_W-1:0]);
    endfunction

    // two-input add that clips instead of wrapping
    function automatic word_t sat_add(input word_t a, input word_t b);
        logic signed [DATA_W:0] s;
        s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        if (s[DATA_W] != s[DATA_W-1]) return s[DATA_W] ? WORD_MIN : WORD_MAX;
        return word_t'(s[DATA_W-1:0]);
    endfunction

endpackage

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
#(
    parameter int IMG_W = 28,
    parameter int IMG_H = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  word_t              pixel_in,
    output logic               win_valid,
    output word_t [TAPS-1:0]   win_taps
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H);
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

    pos_state_t     state_q, state_d;
    logic [CW-1:0]  col_q;
    logic [RW-1:0]  row_q;
    word_t          line_q [IMG_W];
    word_t          diag_q;
    word_t          left_q;
    word_t          above;
    logic           row_end;
    logic           img_end;
    logic           win_ok;

    assign above   = line_q[col_q];
    assign row_end = (col_q == COL_LAST);
    assign img_end = row_end && (row_q == ROW_LAST);

    // next position state
    always_comb begin
        state_d = state_q;
        if (valid_in) begin
            unique case (state_q)
                ST_FIRST_ROW: if (row_end) state_d = ST_ROW_HEAD;            // T_ROW0_DONE
                ST_ROW_HEAD:  state_d = ST_BODY;                             // T_HEAD_TO_BODY
                ST_BODY:      if (row_end) state_d = img_end ? ST_FIRST_ROW  // T_IMAGE_DONE
                                                             : ST_ROW_HEAD;  // T_NEXT_ROW
                default:      state_d = ST_FIRST_ROW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FIRST_ROW;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_BODY: win_ok = 1'b1;
            default: win_ok = 1'b0;
        endcase
    end

    // counters, line storage and window registers
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            row_q     <= '0;
            diag_q    <= '0;
            left_q    <= '0;
            win_valid <= 1'b0;
            win_taps  <= '0;
            for (int i = 0; i < IMG_W; i++) line_q[i] <= '0;
        end else begin
            win_valid <= valid_in && win_ok;
            if (valid_in) begin
                win_taps[0]   <= diag_q;
                win_taps[1]   <= above;
                win_taps[2]   <= left_q;
                win_taps[3]   <= pixel_in;
                diag_q        <= above;
                left_q        <= pixel_in;
                line_q[col_q] <= pixel_in;
                if (row_end) begin
                    col_q <= '0;
                    row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(col_q) && $stable(row_q) && $stable(state_q) && !win_valid));

    // R4
    edge_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (row_q == '0 || col_q == '0) |=> !win_valid);

    // R7
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (col_q <= COL_LAST) && (row_q <= ROW_LAST));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && img_end) |=> (col_q == '0 && row_q == '0 && state_q == ST_FIRST_ROW));

endmodule

// File: rtl/conv_mul.sv
module conv_mul
    import conv_pkg::*;
#(
    parameter word_t [TAPS-1:0] COEF = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  word_t [TAPS-1:0] taps_i,
    output logic             out_valid,
    output word_t [TAPS-1:0] scaled_o
);

    logic  prod_vld_q;
    prod_t prod_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_vld_q <= 1'b0;
            out_valid  <= 1'b0;
        end else begin
            prod_vld_q <= in_valid;
            out_valid  <= prod_vld_q;
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[g]   <= '0;
                scaled_o[g] <= '0;
            end else begin
                prod_q[g]   <= prod_t'($signed(taps_i[g])) * prod_t'($signed(COEF[g]));
                scaled_o[g] <= sat_prod(prod_q[g]);
            end
        end

        // R2
        neg_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (prod_vld_q && prod_q[g][PROD_W-1]) |=> scaled_o[g][DATA_W-1]);

        // R2
        pos_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (prod_vld_q && !prod_q[g][PROD_W-1]) |=> !scaled_o[g][DATA_W-1]);
    end

endmodule

// File: rtl/conv_sum.sv
module conv_sum
    import conv_pkg::*;
#(
    parameter word_t BIAS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  word_t [TAPS-1:0] terms_i,
    output logic             out_valid,
    output word_t            result_o
);

    localparam int PAIRS = TAPS / 2;

    logic  pair_vld_q;
    logic  tot_vld_q;
    word_t pair_q [PAIRS];
    word_t tot_q;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) pair_q[g] <= '0;
            else     pair_q[g] <= sat_add(terms_i[2*g], terms_i[2*g+1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_vld_q <= 1'b0;
            tot_vld_q  <= 1'b0;
            out_valid  <= 1'b0;
            tot_q      <= '0;
            result_o   <= '0;
        end else begin
            pair_vld_q <= in_valid;
            tot_vld_q  <= pair_vld_q;
            out_valid  <= tot_vld_q;
            tot_q      <= sat_add(pair_q[0], pair_q[1]);
            result_o   <= sat_add(tot_q, BIAS);
        end
    end

    // R3
    no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_vld_q && !pair_q[0][DATA_W-1] && !pair_q[1][DATA_W-1]) |=> !tot_q[DATA_W-1]);

    // R3
    no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_vld_q && pair_q[0][DATA_W-1] && pair_q[1][DATA_W-1]) |=> tot_q[DATA_W-1]);

endmodule

// File: rtl/conv2x2_stream.sv
module conv2x2_stream
    import conv_pkg::*;
#(
    parameter int    IMG_W = 28,
    parameter int    IMG_H = 28,
    parameter word_t W_TL  = 32'sh3000_0000,
    parameter word_t W_TR  = 32'shE000_0000,
    parameter word_t W_BL  = 32'sh6000_0000,
    parameter word_t W_BR  = 32'shB000_0000,
    parameter word_t BIAS  = 32'sh0800_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] pixel_in,
    output logic              valid_out,
    output logic [DATA_W-1:0] pixel_out
);

    localparam word_t [TAPS-1:0] COEF = {W_BR, W_BL, W_TR, W_TL};
    localparam int LATENCY = 6;

    logic             win_vld;
    word_t [TAPS-1:0] win_taps;
    logic             mul_vld;
    word_t [TAPS-1:0] scaled;
    word_t            result;

    conv_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_window (
        .clk      (clk),
        .rst      (rst),
        .valid_in (valid_in),
        .pixel_in (word_t'(pixel_in)),
        .win_valid(win_vld),
        .win_taps (win_taps)
    );

    conv_mul #(.COEF(COEF)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (win_vld),
        .taps_i   (win_taps),
        .out_valid(mul_vld),
        .scaled_o (scaled)
    );

    conv_sum #(.BIAS(BIAS)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mul_vld),
        .terms_i  (scaled),
        .out_valid(valid_out),
        .result_o (result)
    );

    assign pixel_out = result;

    // cycles since reset, saturating, used only to bound the look-back below
    logic [2:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                          since_q <= '0;
        else if (since_q != 3'(LATENCY))  since_q <= since_q + 1'b1;
    end

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> (since_q == 3'(LATENCY) && $past(valid_in, 6)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> !valid_out);

endmodule

// File: tb/test_conv2x2_stream.sv
module test_conv2x2_stream;

    localparam int CLK_PERIOD = 10;
    localparam int W = 28;
    localparam int H = 28;
    localparam int PIX = W * H;
    localparam int LAT = 6;
    localparam int WATCHDOG = 60000;
    localparam logic [31:0] C_TL = 32'h3000_0000;
    localparam logic [31:0] C_TR = 32'hE000_0000;
    localparam logic [31:0] C_BL = 32'h6000_0000;
    localparam logic [31:0] C_BR = 32'hB000_0000;
    localparam logic [31:0] C_B  = 32'h0800_0000;

    typedef struct { bit v; int d; } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] pixel_in = '0;
    logic        valid_out;
    logic [31:0] pixel_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int seen_out = 0;
    int want_out = 0;
    int sat_hits = 0;
    int seed = 32'h1234_5678;
    bit done = 0;

    exp_t exp_q[$];
    int prev_row[W];
    int cur_row[W];
    int m_col, m_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv2x2_stream #(
        .IMG_W(W), .IMG_H(H),
        .W_TL(C_TL), .W_TR(C_TR), .W_BL(C_BL), .W_BR(C_BR), .BIAS(C_B)
    ) i_conv2x2_stream (
        .clk(clk), .rst(rst), .valid_in(valid_in), .pixel_in(pixel_in),
        .valid_out(valid_out), .pixel_out(pixel_out)
    );

    function automatic longint clip(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint scaled(input int x, input logic [31:0] c);
        longint p;
        p = longint'(x) * longint'(int'(c));
        return clip(p >>> 30);
    endfunction

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_reset();
        m_col = 0;
        m_row = 0;
        for (int i = 0; i < W; i++) begin
            prev_row[i] = 0;
            cur_row[i] = 0;
        end
    endtask

    function automatic exp_t model_beat(input bit v, input int d);
        exp_t e;
        longint a, b, t, y;
        e.v = 0;
        e.d = 0;
        if (!v) return e;
        if (m_row >= 1 && m_col >= 1) begin
            a = clip(scaled(prev_row[m_col-1], C_TL) + scaled(prev_row[m_col], C_TR));
            b = clip(scaled(cur_row[m_col-1], C_BL) + scaled(d, C_BR));
            t = clip(a + b);
            y = clip(t + longint'(int'(C_B)));
            if (y == 64'sd2147483647 || y == -64'sd2147483648) sat_hits++;
            e.v = 1;
            e.d = int'(y);
            want_out++;
        end
        cur_row[m_col] = d;
        m_col++;
        if (m_col == W) begin
            m_col = 0;
            for (int i = 0; i < W; i++) prev_row[i] = cur_row[i];
            m_row = (m_row == H - 1) ? 0 : m_row + 1;
        end
        return e;
    endfunction

    task automatic step(input bit v, input int d);
        exp_t e, g;
        @(negedge clk);
        g = exp_q.pop_front();
        checks++;
        if (valid_out !== g.v) begin
            fails++;
            $display("FAIL R5/R4 valid_out: actual %0b expected %0b at cycle %0d", valid_out, g.v, cycles);
        end
        if (valid_out === 1'b1) seen_out++;
        if (g.v) begin
            checks++;
            if (pixel_out !== g.d) begin
                fails++;
                $display("FAIL R1/R2/R3/R6 pixel_out: actual %h expected %h at cycle %0d",
                         pixel_out, g.d, cycles);
            end
        end
        valid_in = v;
        pixel_in = v ? d : rnd();
        e = model_beat(v, d);
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t z;
        @(negedge clk);
        rst = 1'b1;
        valid_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R8: output cleared by the reset edge
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R8 valid_out after reset: actual %0b expected 0", valid_out);
        end
        exp_q.delete();
        z.v = 0;
        z.d = 0;
        for (int i = 0; i < LAT; i++) exp_q.push_back(z);
        model_reset();
    endtask

    function automatic int pix_of(input int kind, input int r, input int c);
        case (kind)
            1: return (c % 2 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
            2: return (r % 2 == 0) ? (32'h7FF0_0000 | (rnd() & 32'hFFFF))
                                   : (32'h8010_0000 | (rnd() & 32'hFFFF));
            3: return (rnd() | 32'h8000_0000);
            default: return rnd();
        endcase
    endfunction

    // gaps: 0 none, otherwise one idle beat about every 4
    task automatic send_pixels(input int kind, input int count, input bit gaps);
        for (int n = 0; n < count; n++) begin
            if (gaps) begin
                while ((rnd() & 3) == 0) step(1'b0, 0);
            end
            step(1'b1, pix_of(kind, n / W, n % W));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1/R2/R3/R6: random image with idle beats
        send_pixels(0, PIX, 1'b1);
        // R7: back-to-back images, extremes for clipping
        send_pixels(1, PIX, 1'b0);
        send_pixels(2, PIX, 1'b0);
        // R8: reset part way through an image, then a full image
        send_pixels(0, PIX / 2 + 5, 1'b0);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0);
        checks++;
        if (seen_out !== want_out) begin
            fails++;
            $display("FAIL R4/R7 output count: actual %0d expected %0d", seen_out, want_out);
        end
        do_reset();
        seen_out = 0;
        want_out = 0;
        send_pixels(3, PIX, 1'b1);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0);
        // R4: one full image after reset gives 27x27 outputs
        checks++;
        if (seen_out !== (W - 1) * (H - 1)) begin
            fails++;
            $display("FAIL R4 outputs per image: actual %0d expected %0d", seen_out, (W - 1) * (H - 1));
        end
        done = 1;
        finish_run();
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

endmodule